// File: doc/BRIEF.md
# Capability Permission Checker

This block keeps the permission vectors of a small file of capability registers and applies the permission rules for the instructions that move them. A command port carries an operation code, a destination register, a source register and a 64-bit general-purpose operand. The program-counter capability's permissions arrive on their own port. One bit of that vector grants access to system registers. It guards five privileged capability registers and the 16-bit cause register.

Allowed commands change the register file or the cause register at the next clock edge. A command that breaks the access rule leaves the file and the transfer untouched. Instead, it loads the cause register with the shared violation code and the offending register number, and it raises a one-cycle exception output. Reserved permission bits are treated as ordinary data: copies carry them and the AND operation masks them.

The permission vector is 31 bits wide. Its fields are: software bits [30:15], a reserved group [14:11], the system-register access bit [10], reserved bits [9] and [8], the seal bit [7], and hardware bits [6:0].

Top module: `cap_perm_unit`

## Requirements
- R1: After reset every capability register holds the null value (all 31 bits zero, reserved bits included), the cause register is zero, and both `exc_o` and `res_valid_o` are low.
- R2: Operation code 4 (AND) writes to register `cmd_cd` the source register `cmd_cb` ANDed bit by bit with `cmd_gpr[30:0]`. Operand bits [63:31] have no effect.
- R3: Reserved bits [14:11], [9] and [8] are never cleared by the block itself. Operation code 3 (copy) carries them unchanged, and AND masks them with the matching operand bits.
- R4: Registers 27 to 31 are privileged. Operation codes 1, 2, 3 and 4 that name a privileged destination, and codes 3 and 4 that name a privileged source, need bit 10 of `pcc_perms`. When that bit is clear, no register is written, `exc_o` is high for the following cycle, and the cause register becomes code 0x18 in bits [15:8] with the register number in bits [7:0]. When both registers are privileged, the source is reported.
- R5: Any command that names only registers 0 to 26 is carried out whatever the value of `pcc_perms`.
- R6: Operation code 5 (cause read) needs bit 10 of `pcc_perms`. When allowed, the cycle after the command `res_o` holds the cause register zero-extended to 64 bits and `res_valid_o` is high. When refused, `res_valid_o` stays low, `exc_o` rises, and the cause register becomes 0x18FF.
- R7: Operation code 6 (cause write) needs bit 10 of `pcc_perms`. When allowed, the cause register takes `cmd_gpr[15:0]` at the next edge. When refused, the cause register becomes 0x18FF instead.
- R8: Operation code 2 (clear) writes the null value, all zero, to register `cmd_cd`.
- R9: `exc_o` is high for exactly one cycle per refused command. It is low after every allowed command and after operation codes 0 and 7 (no operation).
- R10: Operation code 1 (load) writes `cmd_gpr[30:0]` to register `cmd_cd`.
- R11: Only bit 10 of `pcc_perms` affects whether a command is allowed.
- R12: `peek_perms` shows the stored vector of register `peek_sel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Operation code, 0 and 7 do nothing |
| cmd_cd | input | 5 | Destination capability register |
| cmd_cb | input | 5 | Source capability register |
| cmd_gpr | input | 64 | General-purpose operand |
| pcc_perms | input | 31 | Program-counter capability permissions |
| peek_sel | input | 5 | Register selected for observation |
| peek_perms | output | 31 | Permissions of the selected register |
| cause_o | output | 16 | Current cause register |
| res_o | output | 64 | Zero-extended cause from the last allowed read |
| res_valid_o | output | 1 | One-cycle strobe for an allowed cause read |
| exc_o | output | 1 | One-cycle exception strobe |

## Verification
The assertions assume that a command is presented for a single cycle and that `pcc_perms` is stable across the edge that samples it. The bench drives every input on the falling edge, so both hold. The bench also assumes that nothing but refusals and allowed cause writes alter the cause register, and it keeps that true by issuing cause writes only through the command port. The sweeps cover every register number with the access bit both set and clear. With the access bit clear, every other bit of `pcc_perms` is set, so any use of those bits would show.

// File: rtl/cap_perm_unit.sv
module cap_perm_unit #(
  parameter int NREG       = 32,
  parameter int PW         = 31,
  parameter int XW         = 64,
  parameter int CW         = 16,
  parameter int PRIV_FIRST = 27,
  parameter int SYS_BIT    = 10,
  parameter logic [7:0] EXC_CODE = 8'h18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               cmd_op,
  input  logic [$clog2(NREG)-1:0]  cmd_cd,
  input  logic [$clog2(NREG)-1:0]  cmd_cb,
  input  logic [XW-1:0]            cmd_gpr,
  input  logic [PW-1:0]            pcc_perms,
  input  logic [$clog2(NREG)-1:0]  peek_sel,
  output logic [PW-1:0]            peek_perms,
  output logic [CW-1:0]            cause_o,
  output logic [XW-1:0]            res_o,
  output logic                     res_valid_o,
  output logic                     exc_o
);
  localparam int AW = $clog2(NREG);
  localparam int NW = CW - 8;
  localparam logic [AW-1:0] PRIV_A = AW'(PRIV_FIRST);
  localparam logic [2:0] OP_LOAD = 3'd1, OP_CLEAR = 3'd2, OP_COPY = 3'd3,
                         OP_AND = 3'd4, OP_RDC = 3'd5, OP_WRC = 3'd6;

  logic [PW-1:0] caps [NREG];
  logic [PW-1:0] new_perm;
  logic [NW-1:0] bad_num;

  wire uses_cb  = (cmd_op == OP_COPY) || (cmd_op == OP_AND);
  wire uses_cd  = uses_cb || (cmd_op == OP_LOAD) || (cmd_op == OP_CLEAR);
  wire is_cause = (cmd_op == OP_RDC) || (cmd_op == OP_WRC);
  wire sys_ok   = pcc_perms[SYS_BIT];

  wire cb_bad  = uses_cb && (cmd_cb >= PRIV_A) && !sys_ok;
  wire cd_bad  = uses_cd && (cmd_cd >= PRIV_A) && !sys_ok;
  wire cz_bad  = is_cause && !sys_ok;
  wire viol    = cb_bad || cd_bad || cz_bad;

  assign bad_num = cb_bad ? NW'(cmd_cb) : cd_bad ? NW'(cmd_cd) : '1;
  assign peek_perms = caps[peek_sel];

  always_comb begin
    case (cmd_op)
      OP_LOAD: new_perm = cmd_gpr[PW-1:0];
      OP_COPY: new_perm = caps[cmd_cb];
      OP_AND:  new_perm = caps[cmd_cb] & cmd_gpr[PW-1:0];
      default: new_perm = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) caps[i] <= '0;
    end else if (uses_cd && !viol) begin
      caps[cmd_cd] <= new_perm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_o     <= '0;
      res_o       <= '0;
      res_valid_o <= 1'b0;
      exc_o       <= 1'b0;
    end else begin
      exc_o       <= viol;
      res_valid_o <= (cmd_op == OP_RDC) && !viol;
      if (viol)
        cause_o <= {EXC_CODE, bad_num};
      else if (cmd_op == OP_WRC)
        cause_o <= cmd_gpr[CW-1:0];
      if ((cmd_op == OP_RDC) && !viol)
        res_o <= XW'(cause_o);
    end
  end
endmodule

module cap_perm_unit_chk #(
  parameter int NREG       = 32,
  parameter int PW         = 31,
  parameter int XW         = 64,
  parameter int CW         = 16,
  parameter int PRIV_FIRST = 27,
  parameter int SYS_BIT    = 10,
  parameter logic [7:0] EXC_CODE = 8'h18
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [2:0]              cmd_op,
  input logic [$clog2(NREG)-1:0] cmd_cd,
  input logic [$clog2(NREG)-1:0] cmd_cb,
  input logic [PW-1:0]           pcc_perms,
  input logic [CW-1:0]           cause_o,
  input logic [XW-1:0]           res_o,
  input logic                    res_valid_o,
  input logic                    exc_o
);
  localparam int AW = $clog2(NREG);
  localparam logic [AW-1:0] PRIV_A = AW'(PRIV_FIRST);

  wire low_only = ((cmd_op == 3'd1) || (cmd_op == 3'd2)) && (cmd_cd < PRIV_A)
               || ((cmd_op == 3'd3) || (cmd_op == 3'd4)) && (cmd_cd < PRIV_A) && (cmd_cb < PRIV_A);

  a_r4_exc_code: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> cause_o[CW-1:CW-8] == EXC_CODE);

  a_r11_exc_needs_no_sys: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> !$past(pcc_perms[SYS_BIT]));

  a_r5_low_regs_allowed: assert property (@(posedge clk) disable iff (!rst_n)
    low_only |=> !exc_o);

  a_r6_zero_extended: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> res_o[XW-1:CW] == '0);

  a_r6_read_or_exc: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_o && res_valid_o));

  a_r7_cause_source: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cause_o) |-> (exc_o || $past(cmd_op) == 3'd6));
endmodule

bind cap_perm_unit cap_perm_unit_chk #(
  .NREG(NREG), .PW(PW), .XW(XW), .CW(CW),
  .PRIV_FIRST(PRIV_FIRST), .SYS_BIT(SYS_BIT), .EXC_CODE(EXC_CODE)
) u_chk (.*);

// File: tb/test_cap_perm_unit.sv
module test_cap_perm_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [4:0]  cmd_cd = '0, cmd_cb = '0, peek_sel = '0;
  logic [63:0] cmd_gpr = '0;
  logic [30:0] pcc_perms = '0;
  logic [30:0] peek_perms;
  logic [15:0] cause_o;
  logic [63:0] res_o;
  logic        res_valid_o, exc_o;

  int checks = 0, errors = 0;
  logic [30:0] m_caps [32];
  logic [15:0] m_cause;
  logic [63:0] m_res;

  localparam logic [30:0] SYS_ON  = 31'h0000_0400;
  localparam logic [30:0] SYS_OFF = 31'h7FFF_FBFF;

  always #10 clk = ~clk;

  cap_perm_unit i_cap_perm_unit (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [30:0] pat(int n);
    logic [31:0] v = 32'(n) * 32'h9E37_79B1 ^ 32'h2AAA_5555;
    return v[30:0];
  endfunction

  task automatic run(string req, logic [2:0] op, logic [4:0] cd, logic [4:0] cb,
                     logic [63:0] gpr, logic [30:0] pcc);
    bit viol = 0, rv = 0;
    logic [7:0] rn = 8'hFF;
    bit sys = pcc[10];
    bit ucb = (op == 3) || (op == 4);
    bit ucd = ucb || (op == 1) || (op == 2);
    if (ucb && cb >= 27 && !sys) begin viol = 1; rn = 8'(cb); end
    else if (ucd && cd >= 27 && !sys) begin viol = 1; rn = 8'(cd); end
    else if ((op == 5 || op == 6) && !sys) viol = 1;
    if (viol) m_cause = {8'h18, rn};
    else begin
      case (op)
        1: m_caps[cd] = gpr[30:0];
        2: m_caps[cd] = '0;
        3: m_caps[cd] = m_caps[cb];
        4: m_caps[cd] = m_caps[cb] & gpr[30:0];
        5: begin m_res = {48'd0, m_cause}; rv = 1; end
        6: m_cause = gpr[15:0];
        default: ;
      endcase
    end
    @(negedge clk);
    cmd_op = op; cmd_cd = cd; cmd_cb = cb; cmd_gpr = gpr; pcc_perms = pcc;
    @(posedge clk); #2;
    cmd_op = 3'd0; peek_sel = cd; #1;
    check({req, " exc"}, 64'(exc_o), 64'(viol));
    check({req, " cause"}, 64'(cause_o), 64'(m_cause));
    check({req, " dest"}, 64'(peek_perms), 64'(m_caps[cd]));
    check({req, " rvalid"}, 64'(res_valid_o), 64'(rv));
    if (rv) check({req, " res"}, res_o, m_res);
  endtask

  task automatic sweep_regs(string req);
    for (int n = 0; n < 32; n++) begin
      peek_sel = 5'(n); #1;
      check(req, 64'(peek_perms), 64'(m_caps[n]));
    end
  endtask

  initial begin
    for (int n = 0; n < 32; n++) m_caps[n] = '0;
    m_cause = '0; m_res = '0;
    repeat (3) @(posedge clk);
    #2; rst_n = 1'b1;
    // R1 reset state
    check("R1 exc", 64'(exc_o), 0);
    check("R1 rvalid", 64'(res_valid_o), 0);
    check("R1 cause", 64'(cause_o), 0);
    sweep_regs("R1 null regs");

    // R10 load every register with access granted
    for (int n = 0; n < 32; n++)
      run("R10 load", 3'd1, 5'(n), 5'd0, {33'h1_FFFF_FFFF, pat(n)}, SYS_ON);
    // R4 R5 R11 load without access bit, other pcc bits set
    for (int n = 0; n < 32; n++)
      run(n >= 27 ? "R4 load refused" : "R5 load low", 3'd1, 5'(n), 5'd0, 64'(~pat(n)), SYS_OFF);
    sweep_regs("R4 state after loads");

    // R9 single-cycle exception
    run("R9 refused", 3'd1, 5'd29, 5'd0, 64'h0, SYS_OFF);
    run("R9 nop after exc", 3'd0, 5'd29, 5'd0, 64'h0, SYS_OFF);
    run("R9 nop7", 3'd7, 5'd3, 5'd3, 64'h0, SYS_OFF);

    // R3 copy sweeps, R4 source reported first
    for (int s = 0; s < 32; s += 3)
      for (int d = 1; d < 32; d += 5) begin
        run("R3 copy sys", 3'd3, 5'(d), 5'(s), 64'h0, SYS_ON);
        run("R4 copy nosys", 3'd3, 5'((d + 7) % 32), 5'((s + 11) % 32), 64'h0, SYS_OFF);
      end
    run("R4 both priv src first", 3'd3, 5'd31, 5'd27, 64'h0, SYS_OFF);

    // R3 reserved bits carried by copy
    run("R3 load reserved", 3'd1, 5'd4, 5'd0, 64'h7B00, SYS_ON);
    run("R3 copy reserved", 3'd3, 5'd5, 5'd4, 64'h0, SYS_OFF);

    // R2 R3 AND with several masks
    for (int k = 0; k < 6; k++) begin
      logic [63:0] m;
      case (k)
        0: m = 64'hFFFF_FFFF_FFFF_FFFF;
        1: m = 64'hFFFF_FFFF_8000_0000;
        2: m = 64'h0000_0000_0000_7B00;
        3: m = 64'h0000_0000_0000_0400;
        4: m = 64'hDEAD_BEEF_5555_AAAA;
        default: m = 64'h0;
      endcase
      for (int d = 0; d < 32; d += 4) begin
        run("R2 and sys", 3'd4, 5'(d), 5'((d * 7 + k) % 32), m, SYS_ON);
        run("R2 and nosys", 3'd4, 5'((d + 27) % 32), 5'((d + k) % 32), m, SYS_OFF);
      end
    end

    // R8 clear
    run("R8 clear low", 3'd2, 5'd9, 5'd0, 64'hFFFF, SYS_OFF);
    run("R8 clear priv refused", 3'd2, 5'd30, 5'd0, 64'h0, SYS_OFF);
    run("R8 clear priv", 3'd2, 5'd30, 5'd0, 64'h0, SYS_ON);

    // R6 R7 cause register
    run("R7 write", 3'd6, 5'd0, 5'd0, 64'hFFFF_FFFF_FFFF_A5C3, SYS_ON);
    run("R6 read", 3'd5, 5'd0, 5'd0, 64'h0, SYS_ON);
    run("R7 write refused", 3'd6, 5'd0, 5'd0, 64'h1234, SYS_OFF);
    run("R6 read after refused", 3'd5, 5'd0, 5'd0, 64'h0, SYS_ON);
    run("R7 write ffff", 3'd6, 5'd0, 5'd0, 64'hFFFF, SYS_ON);
    run("R6 read refused", 3'd5, 5'd0, 5'd0, 64'h0, SYS_OFF);
    run("R6 read code", 3'd5, 5'd0, 5'd0, 64'h0, SYS_ON);
    run("R11 read other bits clear", 3'd5, 5'd0, 5'd0, 64'h0, SYS_ON);

    sweep_regs("R12 final state");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule